// File: doc/BRIEF.md
# Burst beat address and byte-lane sequencer

This block takes one burst descriptor and walks through its beats one at a time. The descriptor holds a start address, a 3-bit size code, an 8-bit length and a 2-bit burst kind. For every beat the block presents the beat address together with the lowest and highest byte lane that the beat occupies on a data bus `BUS_BYTES` wide. It moves no data. A bus master or a memory-side adapter uses it to produce addresses and byte-lane ranges for a data path it controls.

A descriptor is taken on a valid/ready handshake. Beats leave on a second valid/ready stream, and the final beat is flagged. While a burst is in progress the block accepts no new descriptor. It becomes free again in the cycle after the final beat has been handshaken. A wrapping burst whose length is not one of the four legal values raises an error flag for the whole burst. Such a burst is still sequenced, with incrementing addresses.

Top module: `burst_lane_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `beat_valid` is 0.
- R2: A descriptor is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `beat_valid` is 1 and `req_ready` is 0. Exactly `req_len`+1 beats are produced. `beat_last` is 1 only on the final beat. After the final beat is handshaken, `beat_valid` is 0 and `req_ready` is 1 in the next cycle.
- R3: While `beat_valid` is 1 and `beat_ready` is 0, the outputs `beat_addr`, `beat_lo`, `beat_hi` and `beat_last` keep their values into the next cycle.
- R4: Beat 0 of every burst, of any kind, outputs the start address unchanged, including an unaligned one.
- R5: Kind code 2'b00 (fixed) gives every beat the start address. Every beat also carries the same lane bounds as beat 0.
- R6: Kind codes 2'b01 (incrementing) and 2'b11 (treated the same way) give beat N>0 the address align(start, 2^size) + N*2^size. Here 2^size is the number of bytes per beat.
- R7: Kind code 2'b10 (wrapping) with length 1, 3, 7 or 15 uses a window of size 2^size*(len+1), which starts at the start address aligned down to that size. A beat N>0 whose R6-style address reaches the window end has the window size subtracted from it.
- R8: Kind 2'b10 with any other length holds `wrap_err` at 1 on every beat of that burst and produces incrementing addresses as in R6. In every other case `wrap_err` is 0.
- R9: On beat 0 (and on every beat of a fixed burst), `beat_lo` is the start address modulo `BUS_BYTES`. `beat_hi` is (align(start, 2^size) + 2^size - 1) modulo `BUS_BYTES`.
- R10: On beats N>0 of non-fixed bursts, `beat_lo` is the beat address modulo `BUS_BYTES` and `beat_hi` = `beat_lo` + 2^size - 1. The size code must not exceed log2(`BUS_BYTES`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block is idle and will take a descriptor |
| req_addr | input | ADDR_W | Start address |
| req_size | input | 3 | Size code, bytes per beat = 2^code |
| req_len | input | 8 | Beat count minus one |
| req_kind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 incrementing |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Consumer takes the presented beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_lo | output | log2(BUS_BYTES) | Lowest active byte lane |
| beat_hi | output | log2(BUS_BYTES) | Highest active byte lane |
| beat_last | output | 1 | Current beat is the final one |
| wrap_err | output | 1 | Current burst is a wrap with an illegal length |

## Verification
The bench builds the block with its defaults: a 32-bit address and an 8-byte bus, so the lane indices are 3 bits wide. Size codes 0 to 3 then give beats narrower than the bus and beats exactly as wide as it. Unaligned starts put the first-beat lane range in the middle of a bus word. A 256-beat burst uses the full length field, and wraps of 8 and 16 beats cross bus words inside their window. Three backpressure patterns on `beat_ready` cause stalls on first, middle and last beats, and a descriptor queued behind a running burst tests the gap between bursts.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef logic [63:0] wide_t;

  typedef enum logic [1:0] {
    KIND_FIXED = 2'b00,
    KIND_INCR  = 2'b01,
    KIND_WRAP  = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  // Clear the low sh bits of an address.
  function automatic wide_t align_down(wide_t a, int unsigned sh);
    return (a >> sh) << sh;
  endfunction

  // Wrap bursts are legal with 2, 4, 8 or 16 beats only.
  function automatic logic wrap_len_ok(logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

  // log2 of the wrap window in bytes: size code plus log2 of the beat count.
  function automatic int unsigned wrap_shift(logic [2:0] size, logic [7:0] len);
    int unsigned s;
    s = int'(size);
    case (len)
      8'd1:    return s + 1;
      8'd3:    return s + 2;
      8'd7:    return s + 3;
      8'd15:   return s + 4;
      default: return s;
    endcase
  endfunction

  function automatic wide_t window_base(wide_t start, logic [2:0] size, logic [7:0] len);
    return align_down(start, wrap_shift(size, len));
  endfunction

  function automatic wide_t window_span(logic [2:0] size, logic [7:0] len);
    return wide_t'(1) << wrap_shift(size, len);
  endfunction

  // Address of beat idx of a burst.
  function automatic wide_t step_address(wide_t start, logic [2:0] size, logic [7:0] len,
                                         kind_e kind, logic legal_wrap, logic [7:0] idx);
    wide_t a;
    wide_t lim;
    if (idx == 8'd0 || kind == KIND_FIXED) return start;
    a = align_down(start, int'(size)) + (wide_t'(idx) << size);
    if (kind == KIND_WRAP && legal_wrap) begin
      lim = window_base(start, size, len) + window_span(size, len);
      if (a >= lim) a = a - window_span(size, len);
    end
    return a;
  endfunction

  // Top lane of the first beat, before reduction to the lane width.
  function automatic wide_t first_top_lane(wide_t start, logic [2:0] size, int unsigned bus_sh);
    return align_down(start, int'(size)) + (wide_t'(1) << size) - wide_t'(1)
           - align_down(start, bus_sh);
  endfunction

endpackage

// File: rtl/bls_desc_hold.sv
module bls_desc_hold
  import bls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        in_size,
  input  logic [7:0]        in_len,
  input  logic [1:0]        in_kind,
  output logic [ADDR_W-1:0] cur_start,
  output logic [2:0]        cur_size,
  output logic [7:0]        cur_len,
  output kind_e             cur_kind,
  output logic              cur_bad
);

  logic bad_in;
  assign bad_in = (kind_e'(in_kind) == KIND_WRAP) && !wrap_len_ok(in_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start <= '0;
      cur_size  <= '0;
      cur_len   <= '0;
      cur_kind  <= KIND_FIXED;
      cur_bad   <= 1'b0;
    end else if (load) begin
      cur_start <= in_addr;
      cur_size  <= in_size;
      cur_len   <= in_len;
      cur_kind  <= kind_e'(in_kind);
      cur_bad   <= bad_in;
    end
  end

endmodule

// File: rtl/bls_beat_step.sv
module bls_beat_step (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       advance,
  input  logic [7:0] len,
  output logic       busy,
  output logic [7:0] idx,
  output logic       last
);

  assign last = busy && (idx == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (advance) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + 8'd1;
    end
  end

endmodule

// File: rtl/bls_lane_map.sv
module bls_lane_map
  import bls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [2:0]        size,
  input  logic [7:0]        len,
  input  kind_e             kind,
  input  logic              bad,
  input  logic [7:0]        idx,
  output logic [ADDR_W-1:0] addr,
  output logic [LANE_W-1:0] lo,
  output logic [LANE_W-1:0] hi,
  output wide_t             win_base,
  output wide_t             win_span
);

  wide_t wstart;
  wide_t waddr;
  wide_t top0;
  logic  use_first;

  if (ADDR_W < 64) begin : g_ext
    assign wstart = {{(64 - ADDR_W){1'b0}}, start};
  end else begin : g_full
    assign wstart = start[63:0];
  end

  assign waddr     = step_address(wstart, size, len, kind, !bad, idx);
  assign addr      = waddr[ADDR_W-1:0];
  assign top0      = first_top_lane(wstart, size, LANE_W);
  assign use_first = (idx == 8'd0) || (kind == KIND_FIXED);
  assign win_base  = window_base(wstart, size, len);
  assign win_span  = window_span(size, len);

  always_comb begin
    if (use_first) begin
      lo = wstart[LANE_W-1:0];
      hi = top0[LANE_W-1:0];
    end else begin
      lo = waddr[LANE_W-1:0];
      hi = lo + LANE_W'((64'd1 << size) - 64'd1);
    end
  end

endmodule

// File: rtl/burst_lane_seq.sv
module burst_lane_seq
  import bls_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [7:0]        req_len,
  input  logic [1:0]        req_kind,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANE_W-1:0] beat_lo,
  output logic [LANE_W-1:0] beat_hi,
  output logic              beat_last,
  output logic              wrap_err
);

  logic              busy;
  logic              take_desc;
  logic              take_beat;
  logic [ADDR_W-1:0] cur_start;
  logic [2:0]        cur_size;
  logic [7:0]        cur_len;
  kind_e             cur_kind;
  logic              cur_bad;
  logic [7:0]        cur_idx;
  logic              at_last;
  wide_t             win_base;
  wide_t             win_span;

  assign req_ready  = !busy;
  assign take_desc  = req_valid && !busy;
  assign take_beat  = busy && beat_ready;
  assign beat_valid = busy;
  assign beat_last  = at_last;
  assign wrap_err   = busy && cur_bad;

  bls_desc_hold #(.ADDR_W(ADDR_W)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_desc),
    .in_addr   (req_addr),
    .in_size   (req_size),
    .in_len    (req_len),
    .in_kind   (req_kind),
    .cur_start (cur_start),
    .cur_size  (cur_size),
    .cur_len   (cur_len),
    .cur_kind  (cur_kind),
    .cur_bad   (cur_bad)
  );

  bls_beat_step u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take_desc),
    .advance (take_beat),
    .len     (cur_len),
    .busy    (busy),
    .idx     (cur_idx),
    .last    (at_last)
  );

  bls_lane_map #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_map (
    .start    (cur_start),
    .size     (cur_size),
    .len      (cur_len),
    .kind     (cur_kind),
    .bad      (cur_bad),
    .idx      (cur_idx),
    .addr     (beat_addr),
    .lo       (beat_lo),
    .hi       (beat_hi),
    .win_base (win_base),
    .win_span (win_span)
  );

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic              beat_last,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LANE_W-1:0] beat_lo,
  input logic [LANE_W-1:0] beat_hi,
  input logic              wrap_err,
  input logic [1:0]        kind,
  input logic [63:0]       win_base,
  input logic [63:0]       win_span
);

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_lo)
                                  && $stable(beat_hi) && $stable(beat_last));

  assert_fixed_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && kind == 2'b00 && $past(beat_valid && beat_ready && !beat_last)
    |-> $stable(beat_addr) && $stable(beat_lo) && $stable(beat_hi));

  assert_wrap_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && kind == 2'b10 && !wrap_err
    |-> 64'(beat_addr) >= win_base && 64'(beat_addr) < win_base + win_span);

  assert_err_only_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && wrap_err |-> kind == 2'b10);

  assert_lane_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_hi >= beat_lo);

endmodule

bind burst_lane_seq bls_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_last  (beat_last),
  .beat_addr  (beat_addr),
  .beat_lo    (beat_lo),
  .beat_hi    (beat_hi),
  .wrap_err   (wrap_err),
  .kind       (cur_kind),
  .win_base   (win_base),
  .win_span   (win_span)
);

// File: tb/tb_burst_lane_seq.sv
module tb_burst_lane_seq;

  localparam int AW = 32;
  localparam int BB = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_size = '0;
  logic [7:0]    req_len = '0;
  logic [1:0]    req_kind = '0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [LW-1:0] beat_lo;
  logic [LW-1:0] beat_hi;
  logic          beat_last;
  logic          wrap_err;

  always #5 clk = ~clk;

  burst_lane_seq #(.ADDR_W(AW), .BUS_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_len(req_len), .req_kind(req_kind),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_lo(beat_lo), .beat_hi(beat_hi), .beat_last(beat_last), .wrap_err(wrap_err)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [LW-1:0] lo;
    logic [LW-1:0] hi;
    logic          last;
    logic          err;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_checks = 0;
  int    n_bad = 0;
  int    rmode = 0;
  bit    done = 1'b0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Independent model of the beat address.
  function automatic longint model_addr(longint s, int sz, int len, int kind, int n);
    longint b, a, cont, base;
    b = longint'(1) << sz;
    if (n == 0 || kind == 0) return s;
    a = (s / b) * b + longint'(n) * b;
    if (kind == 2 && (len == 1 || len == 3 || len == 7 || len == 15)) begin
      cont = b * (len + 1);
      base = (s / cont) * cont;
      a = base + ((a - base) % cont);
    end
    return a & 64'hFFFF_FFFF;
  endfunction

  task automatic send(longint s, int sz, int len, int kind, string tag);
    longint b, a;
    int lo0, hi0, lo, hi;
    bit ok;
    bit err;
    exp_t e;
    b   = longint'(1) << sz;
    lo0 = int'(s % BB);
    hi0 = int'(((s / b) * b) % BB + b - 1);
    err = (kind == 2) && !(len == 1 || len == 3 || len == 7 || len == 15);
    for (int n = 0; n <= len; n++) begin
      a = model_addr(s, sz, len, kind, n);
      if (n == 0 || kind == 0) begin lo = lo0; hi = hi0; end
      else begin lo = int'(a % BB); hi = lo + int'(b) - 1; end
      e.addr = AW'(a);
      e.lo   = LW'(lo);
      e.hi   = LW'(hi);
      e.last = (n == len);
      e.err  = err;
      expq.push_back(e);
      tagq.push_back(tag);
    end
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = AW'(s);
    req_size  = 3'(sz);
    req_len   = 8'(len);
    req_kind  = 2'(kind);
    do begin
      @(negedge clk);
      ok = req_ready;
      @(posedge clk); #1;
    end while (!ok);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (expq.size() != 0 || beat_valid);
    check(req_ready == 1'b1, "R2", "req_ready after burst", req_ready, 1);
  endtask

  // Backpressure on the beat stream.
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk); #1;
      cnt++;
      case (rmode)
        0:       beat_ready = 1'b1;
        1:       beat_ready = (cnt % 3) != 0;
        default: beat_ready = (cnt % 5) == 0;
      endcase
    end
  end

  // Scoreboard monitor.
  logic          held;
  logic [AW-1:0] h_addr;
  logic [LW-1:0] h_lo, h_hi;
  logic          h_last;
  initial held = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(beat_valid && beat_addr == h_addr && beat_lo == h_lo && beat_hi == h_hi
              && beat_last == h_last, "R3", "stall hold addr", beat_addr, h_addr);
      end
      held = 1'b0;
      if (beat_valid) begin
        check(req_ready == 1'b0, "R2", "req_ready while busy", req_ready, 0);
        if (!beat_ready) begin
          held = 1'b1; h_addr = beat_addr; h_lo = beat_lo; h_hi = beat_hi; h_last = beat_last;
        end else if (expq.size() == 0) begin
          check(1'b0, "R2", "unexpected beat", beat_addr, 0);
        end else begin
          exp_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(beat_addr == e.addr, t, "addr", beat_addr, e.addr);
          check(beat_lo == e.lo, t, "lo lane (R9/R10)", beat_lo, e.lo);
          check(beat_hi == e.hi, t, "hi lane (R9/R10)", beat_hi, e.hi);
          check(beat_last == e.last, "R2", "last flag", beat_last, e.last);
          check(wrap_err == e.err, "R8", "wrap_err", wrap_err, e.err);
        end
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    check(beat_valid == 1'b0, "R1", "reset beat_valid", beat_valid, 0);

    rmode = 0;
    send(64'h1003, 2, 3, 1, "R6_R4");     // unaligned incrementing
    drain();
    send(64'h2034, 2, 3, 2, "R7");        // wrap of 4 beats
    drain();
    rmode = 1;
    send(64'h2036, 1, 7, 2, "R7_R4");     // unaligned wrap of 8
    drain();
    send(64'h3005, 0, 4, 0, "R5");        // fixed byte
    drain();
    send(64'h3006, 2, 3, 0, "R5_R9");     // fixed unaligned word
    drain();
    rmode = 2;
    send(64'h4001, 0, 2, 2, "R8");        // illegal wrap length
    drain();
    send(64'h50F, 1, 0, 1, "R2_R9");      // single beat
    drain();
    send(64'h40, 3, 15, 1, "R10");        // full-bus beats
    drain();
    rmode = 1;
    send(64'h7_0009, 0, 15, 2, "R7");     // wrap of 16 single bytes
    send(64'h501, 1, 2, 3, "R6");         // kind 11 queued behind a burst
    drain();
    rmode = 0;
    send(64'hFFFF_FF02, 0, 255, 1, "R6_R10"); // longest burst, address rolls over
    drain();
    send(64'h8005, 3, 1, 2, "R7_R9");     // wrap of 2 full-bus beats
    drain();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule